// File: doc/BRIEF.md
# DMA Descriptor List Generator

This block turns a stream of memory segments, each given as a start address and a byte length, into a list of 128-bit descriptors for a scatter/gather DMA engine. A segment is cut into pieces so that no descriptor spans a 64 KiB-aligned address window. Each piece fits a 16-bit length field. Segments arrive on a valid/ready stream, and a flag marks the final segment of a list. Descriptors leave on a second valid/ready stream.

The generator holds back one descriptor until it knows whether another one follows. Because of this, the end-of-list bit lands on the true final entry without any rewrite. The list is bounded by a parameterised table size. A list that would need more entries is abandoned. The generator then swallows the rest of that list's input and raises a failure alongside its completion pulse, so that the caller can fall back to programmed I/O. A zero-length segment terminates the list early.

Top module: `dma_desc_gen`

## Requirements
- R1: Each descriptor length equals the smaller of the bytes left in the segment and 0x10000 minus the low 16 bits of the current address. No descriptor crosses a 64 KiB boundary, and the lengths of one segment sum to its length.
- R2: A piece that would be exactly 65536 bytes is emitted as two descriptors of 32768 bytes each. No descriptor has a length field of zero.
- R3: Descriptor layout in desc_data_o (bit 127 is the first byte's MSB): [127:96]=0, [95:64]=address, [63:32]=0, [31]=end-of-list, [30:16]=0, [15:0]=length.
- R4: Bit 31 is set only on the last descriptor of a list.
- R5: A list may hold at most MAX_ENTRIES (default 64) descriptors. A list of exactly that many completes normally.
- R6: When one more descriptor is needed beyond the limit, the held descriptor is dropped and no end-of-list bit is emitted. Input is consumed up to and including the segment flagged last. Then done_o and fail_o pulse together for one cycle, with count_o = 0.
- R7: A zero-length segment ends the list. The preceding descriptor carries end-of-list, and later segments up to the last-flagged one are consumed and ignored. If the zero-length segment is the first of the list, the list fails as in R6.
- R8: One cycle after the end-of-list descriptor is accepted, done_o pulses for one cycle with fail_o low and count_o equal to the number of descriptors.
- R9: While desc_valid_o is high and desc_ready_i is low, desc_valid_o stays high and desc_data_o stays stable. No descriptor is lost or repeated.
- R10: After reset, seg_ready_o is 1 and desc_valid_o, done_o and fail_o are 0.
- R11: Consecutive descriptors of one segment have contiguous addresses, and the first descriptor starts at the segment address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment accepted when high with valid |
| seg_addr_i | input | 32 | Segment start address |
| seg_len_i | input | LEN_W | Segment length in bytes |
| seg_last_i | input | 1 | Final segment of the list |
| desc_valid_o | output | 1 | Descriptor offered |
| desc_ready_i | input | 1 | Descriptor taken when high with valid |
| desc_data_o | output | 128 | Descriptor, layout per R3 |
| done_o | output | 1 | One-cycle list completion pulse |
| fail_o | output | 1 | With done_o: list abandoned |
| count_o | output | CNT_W | Descriptor count, valid with done_o |

## Verification
The bench targets several boundary cases. The first is a segment starting on a window boundary with exactly 64 KiB left: a design without the halving rule would emit a zero length field. It also checks addresses that wrap past the top of the 32-bit space, and a segment that needs four pieces; a wrong room computation would cross a boundary or mis-sum the lengths. Lists of exactly 64 and of 67 entries show whether the overflow comparison is off by one. An early zero-length segment shows whether end-of-list lands on the held descriptor. Random-looking output stalls are applied during a multi-segment list, to catch lost or duplicated descriptors.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int unsigned DESC_W      = 128;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned PAGE_BYTES  = 4096;
  localparam int unsigned DESC_BYTES  = 16;
  localparam int unsigned DEF_ENTRIES = PAGE_BYTES / (4 * DESC_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_SKIP,
    ST_FIN
  } gen_state_e;
endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int unsigned LEN_W = 32,
  parameter int unsigned WIN_W = 16
) (
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [WIN_W:0]   len_o,
  output logic             ends_o
);
  localparam logic [WIN_W:0] WIN_BYTES = {1'b1, {WIN_W{1'b0}}};
  localparam logic [WIN_W:0] HALF      = WIN_BYTES >> 1;

  logic [WIN_W:0] room, raw;
  logic           fits, full;

  always_comb begin
    room   = WIN_BYTES - {1'b0, addr_i[WIN_W-1:0]};
    fits   = rem_i <= LEN_W'(room);
    raw    = fits ? rem_i[WIN_W:0] : room;
    // a full window does not fit the length field: take half
    full   = raw == WIN_BYTES;
    len_o  = full ? HALF : raw;
    ends_o = fits && !full;
  end
endmodule

// File: rtl/dma_desc_pack.sv
module dma_desc_pack #(
  parameter int unsigned LEN_FW = 16
) (
  input  logic [31:0]        addr_i,
  input  logic [LEN_FW-1:0]  len_i,
  input  logic               eol_i,
  output logic [127:0]       data_o
);
  logic [63:0] addr_word, ctl_word;

  always_comb begin
    addr_word = {32'h0, addr_i};
    ctl_word  = {32'h0, eol_i, {(31-LEN_FW){1'b0}}, len_i};
    data_o    = {addr_word, ctl_word};
  end
endmodule

// File: rtl/dma_desc_gen.sv
module dma_desc_gen
  import dma_desc_pkg::*;
#(
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned WIN_W       = 16,
  parameter int unsigned MAX_ENTRIES = DEF_ENTRIES,
  localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seg_valid_i,
  output logic               seg_ready_o,
  input  logic [31:0]        seg_addr_i,
  input  logic [LEN_W-1:0]   seg_len_i,
  input  logic               seg_last_i,
  output logic               desc_valid_o,
  input  logic               desc_ready_i,
  output logic [127:0]       desc_data_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [CNT_W-1:0]   count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ENTRIES);

  gen_state_e       state_q;
  logic [31:0]      cur_addr_q, hold_addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [WIN_W-1:0] hold_len_q;
  logic             cur_last_q, fail_pend_q, hold_v_q;
  logic [CNT_W-1:0] cnt_q, cnt_out_q;
  logic             done_q, fail_q;

  logic [WIN_W:0]   chunk_len;
  logic             chunk_ends;
  logic             in_split, room_left, seg_fire, desc_fire, take, ovf, eol;

  dma_chunk_calc #(.LEN_W(LEN_W), .WIN_W(WIN_W)) u_calc (
    .addr_i (cur_addr_q),
    .rem_i  (rem_q),
    .len_o  (chunk_len),
    .ends_o (chunk_ends)
  );

  always_comb begin
    in_split     = state_q == ST_SPLIT;
    room_left    = cnt_q < CNT_MAX;
    seg_ready_o  = (state_q == ST_IDLE) || (state_q == ST_SKIP);
    seg_fire     = seg_valid_i && seg_ready_o;
    eol          = state_q == ST_FIN;
    // held entry leaves only once its successor (or the list end) is known
    desc_valid_o = hold_v_q && ((in_split && room_left) || eol);
    desc_fire    = desc_valid_o && desc_ready_i;
    take         = in_split && room_left && (!hold_v_q || desc_ready_i);
    ovf          = in_split && !room_left;
  end

  dma_desc_pack #(.LEN_FW(WIN_W)) u_pack (
    .addr_i (hold_addr_q),
    .len_i  (hold_len_q),
    .eol_i  (eol),
    .data_o (desc_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_addr_q  <= '0;
      rem_q       <= '0;
      cur_last_q  <= 1'b0;
      fail_pend_q <= 1'b0;
      hold_v_q    <= 1'b0;
      hold_addr_q <= '0;
      hold_len_q  <= '0;
      cnt_q       <= '0;
      cnt_out_q   <= '0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (seg_fire) begin
          if (seg_len_i == '0) begin
            if (cnt_q == '0) begin
              if (seg_last_i) begin
                done_q    <= 1'b1;
                fail_q    <= 1'b1;
                cnt_out_q <= '0;
              end else begin
                fail_pend_q <= 1'b1;
                state_q     <= ST_SKIP;
              end
            end else if (seg_last_i) begin
              state_q <= ST_FIN;
            end else begin
              fail_pend_q <= 1'b0;
              state_q     <= ST_SKIP;
            end
          end else begin
            cur_addr_q <= seg_addr_i;
            rem_q      <= seg_len_i;
            cur_last_q <= seg_last_i;
            state_q    <= ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          if (ovf) begin
            hold_v_q <= 1'b0;
            cnt_q    <= '0;
            if (cur_last_q) begin
              done_q    <= 1'b1;
              fail_q    <= 1'b1;
              cnt_out_q <= '0;
              state_q   <= ST_IDLE;
            end else begin
              fail_pend_q <= 1'b1;
              state_q     <= ST_SKIP;
            end
          end else if (take) begin
            hold_v_q    <= 1'b1;
            hold_addr_q <= cur_addr_q;
            hold_len_q  <= chunk_len[WIN_W-1:0];
            cnt_q       <= cnt_q + 1'b1;
            cur_addr_q  <= cur_addr_q + 32'(chunk_len);
            rem_q       <= rem_q - LEN_W'(chunk_len);
            if (chunk_ends) state_q <= cur_last_q ? ST_FIN : ST_IDLE;
          end
        end
        ST_SKIP: if (seg_fire && seg_last_i) begin
          if (fail_pend_q) begin
            done_q    <= 1'b1;
            fail_q    <= 1'b1;
            cnt_out_q <= '0;
            hold_v_q  <= 1'b0;
            cnt_q     <= '0;
            state_q   <= ST_IDLE;
          end else begin
            state_q <= ST_FIN;
          end
        end
        ST_FIN: if (desc_fire) begin
          done_q    <= 1'b1;
          cnt_out_q <= cnt_q;
          cnt_q     <= '0;
          hold_v_q  <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign count_o = cnt_out_q;

  AST_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> ({2'b0, hold_addr_q[WIN_W-1:0]} + {2'b0, hold_len_q})
                     <= (WIN_W+2)'(1) << WIN_W); // R1
  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_data_o[WIN_W-1:0] != '0); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R5
  AST_FAIL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && count_o == '0); // R6
  AST_EOL_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_ready_i && desc_data_o[31] |=> done_o && !fail_o); // R8
  AST_BP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_data_o)); // R9
endmodule

// File: tb/tb_dma_desc_gen.sv
module tb_dma_desc_gen;
  localparam int CNT_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seg_valid = 1'b0, seg_ready, seg_last = 1'b0;
  logic [31:0] seg_addr = '0, seg_len = '0;
  logic desc_valid, desc_ready = 1'b1;
  logic [127:0] desc_data;
  logic done, fail;
  logic [CNT_W-1:0] count;

  always #10 clk = ~clk;

  dma_desc_gen dut (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_valid_i(seg_valid), .seg_ready_o(seg_ready), .seg_addr_i(seg_addr),
    .seg_len_i(seg_len), .seg_last_i(seg_last),
    .desc_valid_o(desc_valid), .desc_ready_i(desc_ready), .desc_data_o(desc_data),
    .done_o(done), .fail_o(fail), .count_o(count)
  );

  int errors = 0, checks = 0;
  logic [127:0] cap [128];
  int ncap = 0, ndone = 0, nfail = 0;
  logic [CNT_W-1:0] last_cnt = '0;
  bit bp = 1'b0;
  int cyc = 0;

  typedef struct packed {
    logic [31:0] addr; logic [31:0] len; logic [31:0] n;
    logic [31:0] first; logic [31:0] last;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{32'h1000_0000, 32'h0000_0100, 32'd1, 32'h0100, 32'h0100},
    '{32'h0000_FF00, 32'h0000_0200, 32'd2, 32'h0100, 32'h0100},
    '{32'h0002_0000, 32'h0001_0000, 32'd2, 32'h8000, 32'h8000},
    '{32'h0003_0010, 32'h0002_0000, 32'd4, 32'hFFF0, 32'h0010},
    '{32'hFFFF_FFF0, 32'h0000_0020, 32'd2, 32'h0010, 32'h0010},
    '{32'h0000_0001, 32'h0000_FFFF, 32'd1, 32'hFFFF, 32'hFFFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: set ready after negedge, then record what fires at next posedge
  always begin
    @(negedge clk);
    cyc++;
    desc_ready = bp ? (cyc % 3 != 0) : 1'b1;
    #1;
    if (rst_n && desc_valid && desc_ready && ncap < 128) begin
      cap[ncap] = desc_data;
      ncap++;
    end
    if (rst_n && done) begin
      ndone++;
      if (fail) nfail++;
      last_cnt = count;
    end
  end

  task automatic clear_cap();
    ncap = 0; ndone = 0; nfail = 0;
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input bit lst);
    @(negedge clk);
    seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = lst;
    #2;
    while (!seg_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && ndone == 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  // structural checks on captured list
  task automatic check_list(input string tag, input int exp_n, input logic [31:0] total,
                            input logic [31:0] a0, input bit contig);
    int bad_fmt = 0, bad_cross = 0, bad_eol = 0, bad_adj = 0;
    logic [31:0] sum = '0;
    chk(ncap == exp_n, "R1", {tag, " descriptor count"}, 64'(ncap), 64'(exp_n));
    for (int i = 0; i < ncap; i++) begin
      if (cap[i][127:96] != 0 || cap[i][63:32] != 0 || cap[i][30:16] != 0) bad_fmt++;
      if (({16'h0, cap[i][79:64]} + {16'h0, cap[i][15:0]}) > 32'h10000 ||
          cap[i][15:0] == 0) bad_cross++;
      if (cap[i][31] != (i == ncap - 1)) bad_eol++;
      if (contig && i > 0 && cap[i][95:64] != cap[i-1][95:64] + {16'h0, cap[i-1][15:0]}) bad_adj++;
      sum += {16'h0, cap[i][15:0]};
    end
    chk(bad_fmt == 0, "R3", {tag, " zero fields"}, 64'(bad_fmt), 0);
    chk(bad_cross == 0, "R1", {tag, " window crossing"}, 64'(bad_cross), 0);
    chk(bad_eol == 0, "R4", {tag, " end-of-list placement"}, 64'(bad_eol), 0);
    chk(sum == total, "R1", {tag, " length sum"}, 64'(sum), 64'(total));
    if (contig) begin
      chk(bad_adj == 0, "R11", {tag, " contiguity"}, 64'(bad_adj), 0);
      if (ncap > 0) chk(cap[0][95:64] == a0, "R11", {tag, " first address"},
                        64'(cap[0][95:64]), 64'(a0));
    end
    chk(ndone == 1 && nfail == 0, "R8", {tag, " single done without fail"},
        64'(ndone * 16 + nfail), 64'h10);
    chk(last_cnt == CNT_W'(exp_n), "R8", {tag, " count_o"}, 64'(last_cnt), 64'(exp_n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(seg_ready === 1'b1, "R10", "reset seg_ready", 64'(seg_ready), 1);
    chk(desc_valid === 1'b0 && done === 1'b0 && fail === 1'b0, "R10",
        "reset outputs idle", {61'h0, desc_valid, done, fail}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table-driven single-segment lists (R1, R2, R11)
    for (int v = 0; v < 6; v++) begin
      clear_cap();
      bp = (v == 3);
      send_seg(VECS[v].addr, VECS[v].len, 1'b1);
      wait_done();
      check_list($sformatf("vec%0d", v), int'(VECS[v].n), VECS[v].len, VECS[v].addr, 1'b1);
      if (ncap > 0) begin
        chk(cap[0][15:0] == VECS[v].first[15:0], "R2", $sformatf("vec%0d first len", v),
            64'(cap[0][15:0]), 64'(VECS[v].first));
        chk(cap[ncap-1][15:0] == VECS[v].last[15:0], "R1", $sformatf("vec%0d last len", v),
            64'(cap[ncap-1][15:0]), 64'(VECS[v].last));
      end
    end

    // multi-segment list under output stalls (R9, R4)
    clear_cap();
    bp = 1'b1;
    send_seg(32'h0001_FFF0, 32'h30, 1'b0);
    send_seg(32'h0000_5000, 32'h40, 1'b0);
    send_seg(32'h6000_8000, 32'h10000, 1'b1);
    wait_done();
    bp = 1'b0;
    check_list("multi_r9", 5, 32'h10070, 32'h0, 1'b0);
    if (ncap == 5) begin
      chk(cap[0][15:0] == 16'h10 && cap[1][15:0] == 16'h20 && cap[2][15:0] == 16'h40 &&
          cap[3][15:0] == 16'h8000 && cap[4][15:0] == 16'h8000, "R9", "multi lengths in order",
          {cap[0][15:0], cap[1][15:0], cap[3][15:0], cap[4][15:0]}, 64'h0010_0020_8000_8000);
      chk(cap[4][95:64] == 32'h6001_0000, "R9", "multi last address",
          64'(cap[4][95:64]), 64'h6001_0000);
    end

    // zero-length segment mid list (R7)
    clear_cap();
    send_seg(32'h0000_1000, 32'h100, 1'b0);
    send_seg(32'h0000_2000, 32'h0, 1'b0);
    send_seg(32'h0000_3000, 32'h100, 1'b1);
    wait_done();
    check_list("zero_mid_r7", 1, 32'h100, 32'h1000, 1'b1);

    // zero-length first segment (R7)
    clear_cap();
    send_seg(32'h0000_4000, 32'h0, 1'b1);
    wait_done();
    chk(ncap == 0, "R7", "zero first no descriptors", 64'(ncap), 0);
    chk(ndone == 1 && nfail == 1 && last_cnt == 0, "R7", "zero first fails",
        64'(ndone * 16 + nfail), 64'h11);

    // exactly full table (R5)
    clear_cap();
    for (int i = 0; i < 64; i++) send_seg(32'(i * 256), 32'h10, i == 63);
    wait_done();
    check_list("full_r5", 64, 32'd1024, 32'h0, 1'b0);

    // overflow with trailing input (R6)
    clear_cap();
    for (int i = 0; i < 67; i++) send_seg(32'(i * 256), 32'h10, i == 66);
    wait_done();
    begin
      int eols = 0;
      for (int i = 0; i < ncap; i++) if (cap[i][31]) eols++;
      chk(ncap == 63, "R6", "overflow emitted before abort", 64'(ncap), 63);
      chk(eols == 0, "R6", "overflow no end-of-list", 64'(eols), 0);
      chk(ndone == 1 && nfail == 1 && last_cnt == 0, "R6", "overflow fail pulse",
          64'(ndone * 16 + nfail), 64'h11);
    end

    // block recovers after failure
    clear_cap();
    send_seg(32'h0000_7000, 32'h80, 1'b1);
    wait_done();
    check_list("after_fail_r6", 1, 32'h80, 32'h7000, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule